// File: doc/BRIEF.md
# UART receiver with pop-latched error status

This block is the receive half of a UART. It recovers characters from a serial line that is sampled on a tick running at sixteen times the bit rate. Every finished character goes into a small receive FIFO together with three per-character flags: framing, parity and break. The FIFO head is presented at all times. A one-clock read strobe pops the head, so one read returns the data byte together with its own error flags.

A separate status register is loaded only on a read. It then describes the character that the read removed, not the one now waiting at the head. A break (the line held low for a whole character) produces exactly one zero character. The receiver then ignores the line until it has gone high and a new start bit arrives. A write strobe clears the status register, which also carries a sticky overrun flag. An empty flag and a one-clock error interrupt complete the interface.

Top module: `uart_rx_status`

## Requirements
- R1: With `tick_i` high every clock, a bit lasts 16 ticks and data is sent LSB first. A start bit is confirmed low at its middle and each data bit is sampled at its centre. The received byte appears on `rdata_o[7:0]` at the FIFO head.
- R2: If the start bit, all data bits, the parity bit (when enabled) and the stop bit all sample low, exactly one entry is pushed, however long the line then stays low. That entry has data 0x00, the break flag `rdata_o[10]` set, and the framing and parity flags clear.
- R3: After a break, no character is accepted until `rxd_i` has returned high and a new start bit follows. The next character is then received normally.
- R4: `rsr_o[2:0]` changes only on a read (`rd_i` while not empty) or a clear. A read loads it with the flags of the popped entry, so the flags of an unread head entry never appear in it.
- R5: `rdata_o` carries the head entry's flags next to the data: bit 8 framing, bit 9 parity, bit 10 break.
- R6: A stop bit that samples low on a character that is not a break sets the framing flag of that entry.
- R7: With `par_en_i` high, one parity bit follows the data. `par_odd_i` set to 0 selects even parity and 1 selects odd parity. A mismatch sets the parity flag. With `par_en_i` low, no parity bit is expected.
- R8: A pulse on `ecr_wr_i` clears all of `rsr_o`: bit 0 framing, bit 1 parity, bit 2 break, bit 3 overrun.
- R9: A character that completes while the FIFO (depth 4) is full is discarded and sets the overrun flag `rsr_o[3]`. The entries already stored are unchanged.
- R10: `err_irq_o` pulses high for exactly one clock after an entry with any flag set is written into the FIFO. It stays low for clean characters.
- R11: `rx_empty_o` is high whenever the FIFO holds no entry, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversample tick, 16 per bit |
| rxd_i | input | 1 | Serial receive line |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| rd_i | input | 1 | Read strobe; pops the FIFO head |
| ecr_wr_i | input | 1 | Error clear strobe |
| rdata_o | output | 11 | Head entry: {break, parity, framing, data[7:0]} |
| rsr_o | output | 4 | Status: {overrun, break, parity, framing} of the last popped entry |
| rx_empty_o | output | 1 | FIFO empty |
| err_irq_o | output | 1 | One-clock pulse when an errored entry is written |

## Verification
The assertions check on every cycle these properties:
- the status flags hold their value unless a read or a clear occurs;
- a read loads the popped entry's flags;
- a clear empties the register;
- nothing is pushed while the break lock is active;
- the FIFO count stays within bounds;
- the interrupt never lasts two clocks.

Only the bench scenarios can show the following:
- the sampled bit values;
- the parity and framing decisions;
- that one long low line yields a single zero entry, followed by a normal character;
- that a flagged entry waiting at the head stays invisible in the status register until it is popped;
- what an overrun drops.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK
  } rx_state_e;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser import uart_rx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OS     = 16,
  localparam int CW    = $clog2(OS),
  localparam int BW    = $clog2(DATA_W),
  localparam int EW    = DATA_W + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          push_o,
  output logic [EW-1:0] entry_o
);
  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] shift_q;
  logic              low_q, pe_q;
  logic              samp;

  assign samp = tick_i && (cnt_q == CW'(OS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      low_q   <= 1'b1;
      pe_q    <= 1'b0;
      push_o  <= 1'b0;
      entry_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i && state_q != S_IDLE) cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        S_IDLE: begin
          cnt_q <= '0;
          low_q <= 1'b1;
          pe_q  <= 1'b0;
          if (!rxd_i) state_q <= S_START;
        end
        S_START: if (tick_i && cnt_q == CW'(OS/2-1)) begin
          cnt_q   <= '0;
          bit_q   <= '0;
          state_q <= rxd_i ? S_IDLE : S_DATA;
        end
        S_DATA: if (samp) begin
          shift_q <= {rxd_i, shift_q[DATA_W-1:1]};
          low_q   <= low_q & ~rxd_i;
          if (bit_q == BW'(DATA_W-1)) state_q <= par_en_i ? S_PAR : S_STOP;
          else bit_q <= bit_q + 1'b1;
        end
        S_PAR: if (samp) begin
          pe_q    <= rxd_i ^ (^shift_q) ^ par_odd_i;
          low_q   <= low_q & ~rxd_i;
          state_q <= S_STOP;
        end
        S_STOP: if (samp) begin
          push_o <= 1'b1;
          if (low_q && !rxd_i) begin
            // break: single zero entry, then lock until line idles high
            entry_o <= {1'b1, 2'b00, {DATA_W{1'b0}}};
            state_q <= S_BRK;
          end else begin
            entry_o <= {1'b0, pe_q, ~rxd_i, shift_q};
            state_q <= S_IDLE;
          end
        end
        S_BRK: if (rxd_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_BRK_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BRK && $past(state_q) == S_BRK) |-> !push_o); // R3
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [AW:0]      cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= wdata_i;
        wp_q        <= wp_q + 1'b1;
      end
      if (do_pop) rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o); // R9
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W = 8,
  parameter int OS     = 16,
  parameter int DEPTH  = 4,
  localparam int EW    = DATA_W + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          rd_i,
  input  logic          ecr_wr_i,
  output logic [EW-1:0] rdata_o,
  output logic [3:0]    rsr_o,
  output logic          rx_empty_o,
  output logic          err_irq_o
);
  logic          push, full, pop;
  logic [EW-1:0] entry;
  logic [2:0]    flags_q;
  logic          ovr_q;

  uart_rx_deser #(.DATA_W(DATA_W), .OS(OS)) u_deser (
    .clk_i, .rst_ni, .tick_i, .rxd_i, .par_en_i, .par_odd_i,
    .push_o(push), .entry_o(entry)
  );

  uart_rx_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(entry), .pop_i(rd_i),
    .head_o(rdata_o), .full_o(full), .empty_o(rx_empty_o)
  );

  assign pop   = rd_i && !rx_empty_o;
  assign rsr_o = {ovr_q, flags_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q   <= '0;
      ovr_q     <= 1'b0;
      err_irq_o <= 1'b0;
    end else begin
      // status follows the entry just popped, never the waiting head
      if (ecr_wr_i)  flags_q <= '0;
      else if (pop)  flags_q <= rdata_o[EW-1:DATA_W];
      if (push && full) ovr_q <= 1'b1;
      else if (ecr_wr_i) ovr_q <= 1'b0;
      err_irq_o <= push && !full && (|entry[EW-1:DATA_W]);
    end
  end

  AST_RSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop && !ecr_wr_i) |=> $stable(flags_q)); // R4
  AST_RSR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !ecr_wr_i) |=> flags_q == $past(rdata_o[EW-1:DATA_W])); // R4
  AST_RSR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecr_wr_i |=> flags_q == 3'b000); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |=> !err_irq_o); // R10
  AST_EMPTY_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty_o && !push) |=> rx_empty_o); // R11
endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, par_en = 1'b0, par_odd = 1'b0, rd = 1'b0, ecr = 1'b0;
  logic [10:0] rdata;
  logic [3:0]  rsr;
  logic        empty, irq;
  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .rxd_i(rxd),
    .par_en_i(par_en), .par_odd_i(par_odd), .rd_i(rd), .ecr_wr_i(ecr),
    .rdata_o(rdata), .rsr_o(rsr), .rx_empty_o(empty), .err_irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic level(input logic v, input int clocks);
    for (int i = 0; i < clocks; i++) begin
      @(negedge clk);
      rxd = v;
    end
  endtask

  task automatic frame(input logic [7:0] d, input logic pb, input logic stop_b);
    level(1'b0, 16);
    for (int i = 0; i < 8; i++) level(d[i], 16);
    if (par_en) level(pb, 16);
    level(stop_b, 16);
    level(1'b1, 32);
  endtask

  task automatic pop_chk(input string req, input int exp);
    @(negedge clk);
    chk(req, rdata, exp);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); ecr = 1'b1;
    @(negedge clk); ecr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 empty at reset", empty, 1);
    chk("R8 rsr at reset", rsr, 0);
    chk("R10 irq at reset", irq, 0);
  endtask

  task automatic t_basic();
    int c0 = irq_cnt;
    frame(8'hA5, 1'b0, 1'b1);
    chk("R11 not empty", empty, 0);
    pop_chk("R1 byte A5", 11'h0A5);
    chk("R11 empty after pop", empty, 1);
    frame(8'h3E, 1'b0, 1'b1);
    pop_chk("R1 byte 3E", 11'h03E);
    chk("R10 no irq clean", irq_cnt - c0, 0);
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    frame(8'h3C, 1'b0, 1'b1);
    pop_chk("R7 even ok", 11'h03C);
    frame(8'h3C, 1'b1, 1'b1);
    pop_chk("R7 even bad", 11'h23C);
    chk("R4 rsr parity", rsr, 4'h2);
    par_odd = 1'b1;
    frame(8'h01, 1'b0, 1'b1);
    pop_chk("R7 odd ok", 11'h001);
    chk("R4 rsr clean after pop", rsr, 4'h0);
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_framing();
    int c0 = irq_cnt;
    frame(8'h55, 1'b0, 1'b0);
    chk("R10 irq on framing", irq_cnt - c0, 1);
    chk("R4 head flags hidden", rsr, 0);
    pop_chk("R6 R5 framing entry", 11'h155);
    chk("R4 rsr framing", rsr, 4'h1);
    clear();
    chk("R8 clear", rsr, 0);
  endtask

  task automatic t_break();
    int c0 = irq_cnt;
    level(1'b0, 480);
    level(1'b1, 32);
    chk("R10 one irq on break", irq_cnt - c0, 1);
    chk("R4 break hidden before pop", rsr, 0);
    frame(8'h5A, 1'b0, 1'b1);
    pop_chk("R2 break entry", 11'h400);
    chk("R2 rsr break", rsr, 4'h4);
    pop_chk("R3 next char after break", 11'h05A);
    chk("R3 single break entry", empty, 1);
    chk("R4 rsr after clean pop", rsr, 4'h0);
  endtask

  task automatic t_overrun();
    clear();
    for (int i = 0; i < 5; i++) frame(8'h10 + 8'(i), 1'b0, 1'b1);
    chk("R9 overrun flag", rsr, 4'h8);
    for (int i = 0; i < 4; i++) pop_chk("R9 kept entries", 11'h010 + i);
    chk("R9 fifth dropped", empty, 1);
    chk("R9 overrun sticky", rsr[3], 1);
    clear();
    chk("R8 clear overrun", rsr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_parity();
    t_framing();
    t_break();
    t_overrun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule